// File: doc/BRIEF.md
# Three-Stage Delay-Slot Load/Store Core

This block is a compact 32-bit processor core that runs a six-instruction load/store subset: word load, word store, signed set-less-than, branch when a register is zero, relative jump and halt. Instructions flow through three pipeline stages. The fetch stage presents the program counter to a synchronous instruction memory. The decode stage reads the register file and resolves control transfers. The execute stage does the arithmetic and the data-memory access and writes the register file.

Control transfers have one architectural delay slot. The instruction that sits right after a branch or jump always runs, and the fetch that follows it goes to the target. The pipeline therefore never stalls and never discards work on a taken branch. A result in the execute stage is forwarded into the decode-stage operand read, so a dependent instruction can follow its producer directly. After a halt the core stops fetching, stops storing, and holds its state until reset.

Instruction fields: opcode in bits 31:26, first source register in bits 25:21, second field register in bits 20:16, register-type destination in bits 15:11, register-type function code in bits 5:0, 16-bit immediate in bits 15:0, and a 26-bit jump offset in bits 25:0.

Top module: `tri_stage_core`

## Requirements
- R1: While reset is held, imem_addr equals the reset address (0 by default), halted is 0 and dmem_we is 0.
- R2: With no control transfer and no halt, each fetch address is the previous one plus 4. The word returned by instruction memory one clock after an address is presented is the instruction at that address.
- R3: Opcodes are decoded from bits 31:26: 100000 load, 100001 store, 000000 register type, 010000 branch-if-zero, 010001 jump, 001000 halt. Any other opcode changes no register and makes no store.
- R4: A register-type instruction with function code 101010 writes 1 to register bits 15:11 if register bits 25:21 is less than register bits 20:16 as signed values, and 0 otherwise. Any other function code has no effect.
- R5: A load writes the data word at (register bits 25:21 plus the sign-extended immediate) into register bits 20:16. A store writes register bits 20:16 to that address with dmem_we high for one cycle.
- R6: Register 0 reads as zero, and a write to it is discarded.
- R7: Branch-if-zero tests register bits 25:21. If it is zero, the target is the delay-slot address plus the sign-extended 16-bit immediate. Otherwise execution falls through.
- R8: A jump always transfers to the delay-slot address plus the sign-extended 26-bit offset, so backward offsets form loops.
- R9: The instruction after any branch or jump always executes. A skipped instruction never executes, and no cycle is lost, so a program whose halt is dynamic instruction k raises halted exactly k+3 cycles after reset is released.
- R10: An instruction that reads a register written by the instruction just before it, including a load and including a branch test, sees the new value without a stall.
- R11: A halt sets halted. From then on the fetch address stays constant, no store occurs, and halted stays set until reset. The instruction fetched after the halt does not execute.
- R12: A looping pointer-chase program with a backward jump, a forward exit branch and useful delay slots produces the expected store sequence and halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction fetch address |
| imem_rdata | input | 32 | Instruction word, one clock after its address |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | 32 | Load data, combinational from dmem_addr |
| halted | output | 1 | High once a halt has executed |

## Verification
Three programs are used. The first is straight-line and mixes loads, both outcomes of set-less-than, a non-matching function code, an unknown opcode, a load into register 0 and a negative displacement. Through the stored values it separates correct decoding and forwarding from silently ignored or misrouted writes. The second covers a taken branch, a not-taken branch, a forward jump and a branch on a just-loaded register. It tells a delay slot that executes apart from a skipped instruction that wrongly runs, and the exact cycle count of the run shows whether any stall was added. The third is a pointer-chase loop with a backward jump. It checks iteration order and the exit through a taken branch's delay slot, and afterwards the bench watches that the core stays halted with a frozen fetch address.

// File: rtl/tri_core_pkg.sv
`timescale 1ns/1ps
package tri_core_pkg;
    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RIDX = $clog2(NREG);
    localparam int OPW  = 6;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RIDX-1:0] ridx_t;

    typedef enum logic [OPW-1:0] {
        OP_RTYPE = 6'b000000,
        OP_HALT  = 6'b001000,
        OP_BEQZ  = 6'b010000,
        OP_JMP   = 6'b010001,
        OP_LOAD  = 6'b100000,
        OP_STORE = 6'b100001
    } opcode_e;

    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        K_NOP, K_LOAD, K_STORE, K_SLT, K_BEQZ, K_JMP, K_HALT
    } kind_e;

    typedef struct packed {
        kind_e kind;
        ridx_t rs1;
        ridx_t rs2;
        ridx_t rd;
        word_t imm;
    } dec_t;

    typedef struct packed {
        logic  valid;
        kind_e kind;
        ridx_t rd;
        word_t a;
        word_t b;
        word_t imm;
    } exe_t;

    function automatic word_t sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic word_t sext26(input logic [25:0] v);
        return {{(XLEN-26){v[25]}}, v};
    endfunction

    function automatic dec_t decode_word(input word_t ir);
        dec_t d;
        d.rs1  = ir[25:21];
        d.rs2  = ir[20:16];
        d.rd   = '0;
        d.imm  = sext16(ir[15:0]);
        d.kind = K_NOP;
        case (ir[31:26])
            OP_LOAD: begin
                d.kind = K_LOAD;
                d.rd   = ir[20:16];
            end
            OP_STORE: d.kind = K_STORE;
            OP_RTYPE: begin
                if (ir[5:0] == FN_SLT) begin
                    d.kind = K_SLT;
                    d.rd   = ir[15:11];
                end
            end
            OP_BEQZ: d.kind = K_BEQZ;
            OP_JMP: begin
                d.kind = K_JMP;
                d.imm  = sext26(ir[25:0]);
            end
            OP_HALT: d.kind = K_HALT;
            default: d.kind = K_NOP;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/tri_core_fetch.sv
`timescale 1ns/1ps
module tri_core_fetch
    import tri_core_pkg::*;
#(
    parameter word_t RESET_PC = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  dec_halt,
    input  logic  redirect,
    input  word_t target,
    output word_t pc,
    output word_t d_pc,
    output logic  d_valid,
    output logic  hold
);
    localparam word_t STEP = word_t'(XLEN / 8);

    logic stop;

    assign hold = stop | dec_halt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= RESET_PC;
            d_pc    <= RESET_PC;
            d_valid <= 1'b0;
            stop    <= 1'b0;
        end else begin
            stop    <= hold;
            d_valid <= !hold;
            if (!hold) begin
                d_pc <= pc;
                pc   <= redirect ? target : pc + STEP;
            end
        end
    end
endmodule

// File: rtl/tri_core_regfile.sv
`timescale 1ns/1ps
module tri_core_regfile
    import tri_core_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  ridx_t waddr,
    input  word_t wdata,
    input  ridx_t raddr_a,
    input  ridx_t raddr_b,
    output word_t rdata_a,
    output word_t rdata_b
);
    word_t regs [1:NREG-1];

    genvar gi;
    generate
        for (gi = 1; gi < NREG; gi++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    regs[gi] <= '0;
                else if (we && waddr == ridx_t'(gi))
                    regs[gi] <= wdata;
            end
        end
    endgenerate

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/tri_core_decode.sv
`timescale 1ns/1ps
module tri_core_decode
    import tri_core_pkg::*;
(
    input  word_t ir,
    input  logic  valid,
    input  word_t pc,
    input  word_t rf_a,
    input  word_t rf_b,
    input  logic  fw_en,
    input  ridx_t fw_rd,
    input  word_t fw_data,
    output ridx_t ra,
    output ridx_t rb,
    output exe_t  issue,
    output logic  taken,
    output word_t target,
    output logic  is_halt
);
    localparam word_t STEP = word_t'(XLEN / 8);

    dec_t  d;
    word_t opa;
    word_t opb;

    assign d  = decode_word(ir);
    assign ra = d.rs1;
    assign rb = d.rs2;

    // Operand pick: register 0 is hard zero, then the execute-stage result, then the file.
    always_comb begin
        if (d.rs1 == '0)                  opa = '0;
        else if (fw_en && fw_rd == d.rs1) opa = fw_data;
        else                              opa = rf_a;
        if (d.rs2 == '0)                  opb = '0;
        else if (fw_en && fw_rd == d.rs2) opb = fw_data;
        else                              opb = rf_b;
    end

    always_comb begin
        issue.valid = valid;
        issue.kind  = d.kind;
        issue.rd    = d.rd;
        issue.a     = opa;
        issue.b     = opb;
        issue.imm   = d.imm;
    end

    // The delay-slot address is pc + STEP; the target is relative to it.
    assign target  = pc + STEP + d.imm;
    assign taken   = valid && ((d.kind == K_BEQZ && opa == '0) || d.kind == K_JMP);
    assign is_halt = valid && d.kind == K_HALT;
endmodule

// File: rtl/tri_core_execute.sv
`timescale 1ns/1ps
module tri_core_execute
    import tri_core_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  exe_t  issue,
    input  word_t dmem_rdata,
    output word_t dmem_addr,
    output word_t dmem_wdata,
    output logic  dmem_we,
    output logic  wb_en,
    output ridx_t wb_rd,
    output word_t wb_data,
    output logic  halted
);
    exe_t  x;
    logic  lt;

    always_ff @(posedge clk) begin
        if (rst) begin
            x      <= '0;
            halted <= 1'b0;
        end else begin
            x <= issue;
            if (x.valid && x.kind == K_HALT)
                halted <= 1'b1;
        end
    end

    assign lt         = $signed(x.a) < $signed(x.b);
    assign dmem_addr  = x.a + x.imm;
    assign dmem_wdata = x.b;
    assign dmem_we    = x.valid && x.kind == K_STORE;

    always_comb begin
        wb_rd   = x.rd;
        wb_data = '0;
        wb_en   = 1'b0;
        if (x.valid && x.rd != '0) begin
            if (x.kind == K_LOAD) begin
                wb_en   = 1'b1;
                wb_data = dmem_rdata;
            end else if (x.kind == K_SLT) begin
                wb_en   = 1'b1;
                wb_data = {{(XLEN-1){1'b0}}, lt};
            end
        end
    end
endmodule

// File: rtl/tri_stage_core.sv
`timescale 1ns/1ps
module tri_stage_core
    import tri_core_pkg::*;
#(
    parameter word_t RESET_PC = '0
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata,
    output logic        halted
);
    word_t pc, d_pc, br_target, rf_a, rf_b, wb_data;
    logic  d_valid, fetch_hold, br_taken, dec_halt, wb_en;
    ridx_t ra, rb, wb_rd;
    exe_t  issue;

    tri_core_fetch #(.RESET_PC(RESET_PC)) u_fetch (
        .clk(clk), .rst(rst), .dec_halt(dec_halt), .redirect(br_taken),
        .target(br_target), .pc(pc), .d_pc(d_pc), .d_valid(d_valid),
        .hold(fetch_hold)
    );

    tri_core_regfile u_rf (
        .clk(clk), .rst(rst), .we(wb_en), .waddr(wb_rd), .wdata(wb_data),
        .raddr_a(ra), .raddr_b(rb), .rdata_a(rf_a), .rdata_b(rf_b)
    );

    tri_core_decode u_dec (
        .ir(imem_rdata), .valid(d_valid), .pc(d_pc), .rf_a(rf_a), .rf_b(rf_b),
        .fw_en(wb_en), .fw_rd(wb_rd), .fw_data(wb_data), .ra(ra), .rb(rb),
        .issue(issue), .taken(br_taken), .target(br_target), .is_halt(dec_halt)
    );

    tri_core_execute u_exe (
        .clk(clk), .rst(rst), .issue(issue), .dmem_rdata(dmem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .wb_en(wb_en), .wb_rd(wb_rd), .wb_data(wb_data), .halted(halted)
    );

    assign imem_addr = pc;
endmodule

// File: rtl/tri_stage_core_chk.sv
`timescale 1ns/1ps
module tri_stage_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic        dmem_we,
    input logic        halted,
    input logic        fetch_hold,
    input logic        br_taken
);
    p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    p_no_store_halted_r11: assert property (@(posedge clk) disable iff (rst)
        halted |-> !dmem_we);

    p_fetch_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(imem_addr));

    p_seq_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        (!fetch_hold && !br_taken) |=> imem_addr == $past(imem_addr) + 32'd4);

    p_hold_fetch_r11: assert property (@(posedge clk) disable iff (rst)
        fetch_hold |=> $stable(imem_addr));
endmodule

bind tri_stage_core tri_stage_core_chk u_chk (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .dmem_we(dmem_we),
    .halted(halted), .fetch_hold(fetch_hold), .br_taken(br_taken)
);

// File: tb/tri_stage_core_test.sv
`timescale 1ns/1ps
module tri_stage_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, halted;

    int checks = 0;
    int fails  = 0;

    logic [31:0] rom  [0:63];
    logic [31:0] dram [0:63];

    logic [31:0] q_addr [$];
    logic [31:0] q_data [$];
    string       q_tag  [$];

    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    tri_stage_core uut (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata), .halted(halted)
    );

    always_ff @(posedge clk) imem_rdata <= rom[imem_addr[7:2]];
    assign dmem_rdata = dram[dmem_addr[7:2]];
    always_ff @(posedge clk) if (!rst && dmem_we) dram[dmem_addr[7:2]] <= dmem_wdata;

    function automatic logic [31:0] f_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input int imm);
        logic [31:0] v = imm;
        return {op, rs, rt, v[15:0]};
    endfunction
    function automatic logic [31:0] f_lw(input logic [4:0] rt, input int imm, input logic [4:0] rs);
        return f_i(6'b100000, rs, rt, imm);
    endfunction
    function automatic logic [31:0] f_sw(input logic [4:0] rt, input int imm, input logic [4:0] rs);
        return f_i(6'b100001, rs, rt, imm);
    endfunction
    function automatic logic [31:0] f_slt(input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2);
        return {6'b000000, rs1, rs2, rd, 5'd0, 6'b101010};
    endfunction
    function automatic logic [31:0] f_beqz(input logic [4:0] rs, input int off);
        return f_i(6'b010000, rs, 5'd0, off);
    endfunction
    function automatic logic [31:0] f_j(input int off);
        logic [31:0] v = off;
        return {6'b010001, v[25:0]};
    endfunction
    localparam logic [31:0] HALT_W = {6'b001000, 26'd0};

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic expect_store(input logic [31:0] a, input logic [31:0] d, input string tag);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_tag.push_back(tag);
    endtask

    // Monitor: pops the scoreboard on each store.
    logic [31:0] m_a, m_d;
    string       m_t;
    always @(negedge clk) begin
        if (!rst && dmem_we) begin
            if (q_addr.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R11 unexpected store addr actual=%h expected=none (data %h)",
                         dmem_addr, dmem_wdata);
            end else begin
                m_a = q_addr.pop_front();
                m_d = q_data.pop_front();
                m_t = q_tag.pop_front();
                check(dmem_addr == m_a, m_t, "store addr", dmem_addr, m_a);
                check(dmem_wdata == m_d, m_t, "store data", dmem_wdata, m_d);
            end
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin
            rom[i]  = 32'd0;
            dram[i] = 32'd0;
        end
    endtask

    task automatic run_prog(input int halt_idx, input string name);
        int n = 0;
        logic [31:0] frozen;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(imem_addr == 32'd0, "R1", "reset fetch addr", imem_addr, 32'd0);
        check(halted == 1'b0, "R1", "reset halted", {31'd0, halted}, 32'd0);
        check(dmem_we == 1'b0, "R1", "reset store strobe", {31'd0, dmem_we}, 32'd0);
        rst = 1'b0;
        while (n < 500) begin
            @(negedge clk);
            n++;
            if (halted) break;
        end
        check(halted == 1'b1, "R11", {name, " halted reached"}, {31'd0, halted}, 32'd1);
        check(n == halt_idx + 3, "R9", {name, " cycles to halt"}, n, halt_idx + 3);
        frozen = imem_addr;
        repeat (8) @(negedge clk);
        check(halted == 1'b1, "R11", {name, " halted sticky"}, {31'd0, halted}, 32'd1);
        check(imem_addr == frozen, "R11", {name, " fetch frozen"}, imem_addr, frozen);
        check(q_addr.size() == 0, "R11", {name, " stores outstanding"}, q_addr.size(), 0);
        q_addr.delete();
        q_data.delete();
        q_tag.delete();
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        clear_mem();
        // Program 1: straight-line decode, SLT, forwarding, r0, sign extension.
        dram[0] = 32'd5; dram[1] = 32'hFFFF_FFFD; dram[2] = 32'd7; dram[3] = 32'd64;
        rom[0]  = f_lw(5'd1, 0, 5'd0);
        rom[1]  = f_lw(5'd2, 4, 5'd0);
        rom[2]  = f_slt(5'd3, 5'd2, 5'd1);
        rom[3]  = f_sw(5'd3, 16, 5'd0);
        rom[4]  = f_slt(5'd4, 5'd1, 5'd2);
        rom[5]  = f_sw(5'd4, 20, 5'd0);
        rom[6]  = {6'b000000, 5'd1, 5'd1, 5'd3, 5'd0, 6'b100000};
        rom[7]  = f_sw(5'd3, 24, 5'd0);
        rom[8]  = f_lw(5'd0, 8, 5'd0);
        rom[9]  = f_sw(5'd0, 28, 5'd0);
        rom[10] = f_i(6'b100011, 5'd0, 5'd1, 32);
        rom[11] = f_lw(5'd6, 12, 5'd0);
        rom[12] = f_sw(5'd1, -8, 5'd6);
        rom[13] = HALT_W;
        rom[14] = f_sw(5'd1, 0, 5'd0);
        expect_store(32'd16, 32'd1, "R10/R4 slt true forwarded");
        expect_store(32'd20, 32'd0, "R4 slt false");
        expect_store(32'd24, 32'd1, "R4 other funct ignored");
        expect_store(32'd28, 32'd0, "R6 r0 stays zero");
        expect_store(32'd56, 32'd5, "R5/R3 neg offset, unknown opcode");
        run_prog(13, "straight");

        clear_mem();
        // Program 2: branches, jump, delay slots.
        dram[0] = 32'd5; dram[1] = 32'd0;
        rom[0]  = f_lw(5'd1, 0, 5'd0);
        rom[1]  = f_beqz(5'd0, 8);
        rom[2]  = f_sw(5'd1, 32, 5'd0);
        rom[3]  = f_sw(5'd1, 36, 5'd0);
        rom[4]  = f_beqz(5'd1, 100);
        rom[5]  = f_sw(5'd1, 40, 5'd0);
        rom[6]  = f_sw(5'd1, 44, 5'd0);
        rom[7]  = f_j(8);
        rom[8]  = f_sw(5'd1, 48, 5'd0);
        rom[9]  = f_sw(5'd1, 52, 5'd0);
        rom[10] = f_lw(5'd2, 4, 5'd0);
        rom[11] = f_beqz(5'd2, 8);
        rom[12] = f_sw(5'd2, 56, 5'd0);
        rom[13] = f_sw(5'd1, 60, 5'd0);
        rom[14] = HALT_W;
        expect_store(32'd32, 32'd5, "R9 taken branch delay slot");
        expect_store(32'd40, 32'd5, "R7 not-taken delay slot");
        expect_store(32'd44, 32'd5, "R7 fall-through");
        expect_store(32'd48, 32'd5, "R8 jump delay slot");
        expect_store(32'd56, 32'd0, "R10 branch on fresh load");
        run_prog(11, "branch");

        clear_mem();
        // Program 3: pointer-chase loop with backward jump.
        dram[0] = 32'd8;
        dram[2] = 32'd16; dram[3] = 32'd11;
        dram[4] = 32'd24; dram[5] = 32'd22;
        dram[6] = 32'd0;  dram[7] = 32'd33;
        rom[0] = f_lw(5'd1, 0, 5'd0);
        rom[1] = f_lw(5'd2, 4, 5'd1);
        rom[2] = f_sw(5'd2, 64, 5'd0);
        rom[3] = f_lw(5'd1, 0, 5'd1);
        rom[4] = f_beqz(5'd1, 12);
        rom[5] = f_sw(5'd1, 68, 5'd0);
        rom[6] = f_j(-24);
        rom[7] = f_sw(5'd2, 72, 5'd0);
        rom[8] = HALT_W;
        expect_store(32'd64, 32'd11, "R12 node1 payload");
        expect_store(32'd68, 32'd16, "R12 node1 next");
        expect_store(32'd72, 32'd11, "R8 backward jump slot");
        expect_store(32'd64, 32'd22, "R12 node2 payload");
        expect_store(32'd68, 32'd24, "R12 node2 next");
        expect_store(32'd72, 32'd22, "R12 loop slot");
        expect_store(32'd64, 32'd33, "R12 node3 payload");
        expect_store(32'd68, 32'd0,  "R12 exit delay slot");
        run_prog(20, "loop");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule